// File: doc/BRIEF.md
# Message-Framed Receive FIFO

This block buffers the received side of a serial data link between a bit-level deframer and a processor. The deframer marks the start of each message, delivers the message one byte at a time, and then closes it with a two-bit end-of-message status. Bytes go into a 64-location byte store. Each closed message adds one record to a separate 8-entry status queue. A record holds the closing code and the number of bytes in the message. The processor pops a record, then pops that many bytes.

Bytes of a message stay hidden from the reader until the message is closed. If a byte arrives while all 64 locations are in use, the open message is discarded. Messages that were already closed are not touched. The discard is reported as a record with code "partial" and a count of zero. That pair cannot occur for an ordinary aborted or errored message. A sticky error output is raised at the same time. Incoming data is then ignored until the next start-of-message.

Top module: `rxf_msg_fifo`

## Requirements
- R1: After reset, `rd_byte_avail`, `rd_stat_avail` and `full_err` are all 0.
- R2: For a message closed with code 00 (good), the reader gets one record with code 00 and a count equal to the number of bytes. It then gets those bytes in arrival order on `rd_byte`.
- R3: The byte store never holds more than 64 bytes, counting closed and open messages together. A byte that arrives while 64 are held is an overflow.
- R4: On overflow, no byte of the open message ever becomes readable. One record with code 11 (partial) and count 0 is queued, provided the status queue has room.
- R5: Messages closed before an overflow keep their records and bytes, unchanged and in order.
- R6: `full_err` goes to 1 in the cycle after an overflow and holds until a status pop. A status pop clears it in the next cycle, unless a new overflow occurs in the same cycle.
- R7: After an overflow, bytes and end-of-message strobes have no effect until the next `wr_sof`.
- R8: Codes 01 (FCS error) and 10 (abort) are queued as given, with the true byte count. The message's bytes stay readable.
- R9: Bytes or end-of-message strobes that arrive outside an open message are ignored.
- R10: The status queue holds 8 records. A message that closes while 8 records are waiting is discarded completely and sets `full_err`.
- R11: While a message is open, none of its bytes are readable (`rd_byte_avail` does not rise because of it).
- R12: A byte pop while `rd_byte_avail` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_sof | input | 1 | Start of a new message (drops any open one) |
| wr_valid | input | 1 | A received byte is on `wr_data` |
| wr_data | input | 8 | Received byte |
| wr_eom | input | 1 | Closes the open message |
| wr_eom_code | input | 2 | Closing code: 00 good, 01 FCS error, 10 abort |
| rd_byte_pop | input | 1 | Consume the byte on `rd_byte` |
| rd_byte | output | 8 | Oldest readable byte |
| rd_byte_avail | output | 1 | At least one byte of a closed message is waiting |
| rd_stat_pop | input | 1 | Consume the head record; also clears `full_err` |
| rd_stat_avail | output | 1 | At least one record is waiting |
| rd_stat_code | output | 2 | Code of the head record (11 = partial) |
| rd_stat_count | output | 8 | Byte count of the head record |
| full_err | output | 1 | Sticky overflow error |

## Verification
The assertions assume that `wr_sof`, `wr_valid` and `wr_eom` are never high in the same cycle. They also assume the reader pops no more bytes than the records announce. The stimulus meets both conditions: each write event is issued alone in its own cycle, and reads run only in a drain phase that follows the queued records. Random message lengths and codes, and drains skipped at random, drive the block into both kinds of overflow. The byte-store overflow occurs when 64 bytes are held; the status overflow occurs when 8 records are waiting. Directed cases cover stray bytes, empty pops and a mid-message overflow.

// File: rtl/rxf_pkg.sv
// Shared types for the message-framed receive FIFO.
// Assumes byte counts fit in CNT_W bits (store depth below 256).
package rxf_pkg;
    localparam int CNT_W = 8;

    typedef enum logic [1:0] {
        EOM_GOOD    = 2'b00,
        EOM_FCS     = 2'b01,
        EOM_ABORT   = 2'b10,
        EOM_PARTIAL = 2'b11
    } eom_code_e;

    typedef enum logic [1:0] {
        RX_IDLE = 2'b00,
        RX_RECV = 2'b01,
        RX_DROP = 2'b10
    } rx_state_e;
endpackage

// File: rtl/rxf_byte_store.sv
// Byte storage with a write port and a show-ahead read side.
// Only data below commit_ptr is visible to the reader; pops with nothing
// visible are ignored. Assumes the writer never overruns rd_ptr.
module rxf_byte_store #(
    parameter int DEPTH = 64,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [PW-1:0] commit_ptr,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic          avail,
    output logic [PW-1:0] rd_ptr
);
    logic [W-1:0] mem [DEPTH];

    // Write port into the storage array.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign avail = (rd_ptr != commit_ptr);
    assign rdata = mem[rd_ptr[AW-1:0]];

    // Read pointer advances on a pop of visible data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
        end else if (pop && avail) begin
            rd_ptr <= rd_ptr + 1'b1;
        end
    end
endmodule

// File: rtl/rxf_stat_fifo.sv
// Small first-in first-out queue for end-of-message records.
// Pushes when full and pops when empty are ignored.
module rxf_stat_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 10,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         not_empty,
    output logic         full
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [PW-1:0] used;

    assign used      = wp - rp;
    assign full      = (used == PW'(DEPTH));
    assign not_empty = (wp != rp);
    assign head      = mem[rp[AW-1:0]];

    // Record storage write.
    always_ff @(posedge clk) begin
        if (push && !full) begin
            mem[wp[AW-1:0]] <= din;
        end
    end

    // Queue pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push && !full) wp <= wp + 1'b1;
            if (pop && not_empty) rp <= rp + 1'b1;
        end
    end
endmodule

// File: rtl/rxf_wr_ctrl.sv
// Write-side message tracker. Holds a speculative pointer for the open
// message and a commit pointer for closed ones. Closing a message commits
// it and queues a record. An overflow (byte with no free location) or a close
// with the status queue full rolls the message back. Assumes sof, valid and
// eom are never asserted together.
module rxf_wr_ctrl
    import rxf_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof,
    input  logic             valid,
    input  logic             eom,
    input  logic [1:0]       eom_code,
    input  logic [PW-1:0]    rd_ptr,
    input  logic             stat_full,
    output logic             mem_we,
    output logic [AW-1:0]    mem_waddr,
    output logic [PW-1:0]    spec_ptr,
    output logic [PW-1:0]    commit_ptr,
    output logic             rec_push,
    output logic [1:0]       rec_code,
    output logic [CNT_W-1:0] rec_cnt,
    output logic             ovf_evt,
    output rx_state_e        state
);
    rx_state_e        state_nx;
    logic [PW-1:0]    spec_nx, commit_nx;
    logic [CNT_W-1:0] cnt_q, cnt_nx;
    logic [PW-1:0]    occ;
    logic             has_space;

    assign occ       = spec_ptr - rd_ptr;
    assign has_space = (occ < PW'(DEPTH));
    assign mem_waddr = spec_ptr[AW-1:0];

    // Next-state decode for each write-side event.
    always_comb begin
        state_nx  = state;
        spec_nx   = spec_ptr;
        commit_nx = commit_ptr;
        cnt_nx    = cnt_q;
        mem_we    = 1'b0;
        rec_push  = 1'b0;
        rec_code  = EOM_GOOD;
        rec_cnt   = '0;
        ovf_evt   = 1'b0;
        if (sof) begin
            state_nx = RX_RECV;
            spec_nx  = commit_ptr;
            cnt_nx   = '0;
        end else if (state == RX_RECV) begin
            if (valid) begin
                if (has_space) begin
                    mem_we  = 1'b1;
                    spec_nx = spec_ptr + 1'b1;
                    cnt_nx  = cnt_q + 1'b1;
                end else begin
                    spec_nx  = commit_ptr;
                    rec_push = !stat_full;
                    rec_code = EOM_PARTIAL;
                    ovf_evt  = 1'b1;
                    state_nx = RX_DROP;
                end
            end else if (eom) begin
                state_nx = RX_IDLE;
                if (!stat_full) begin
                    rec_push  = 1'b1;
                    rec_code  = eom_code;
                    rec_cnt   = cnt_q;
                    commit_nx = spec_ptr;
                end else begin
                    spec_nx = commit_ptr;
                    ovf_evt = 1'b1;
                end
            end
        end
    end

    // State and pointer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= RX_IDLE;
            spec_ptr   <= '0;
            commit_ptr <= '0;
            cnt_q      <= '0;
        end else begin
            state      <= state_nx;
            spec_ptr   <= spec_nx;
            commit_ptr <= commit_nx;
            cnt_q      <= cnt_nx;
        end
    end
endmodule

// File: rtl/rxf_msg_fifo.sv
// Top of the message-framed receive FIFO: write tracker, byte store,
// status queue and the sticky full-error flag.
module rxf_msg_fifo
    import rxf_pkg::*;
#(
    parameter int DEPTH      = 64,
    parameter int STAT_DEPTH = 8,
    localparam int AW        = $clog2(DEPTH),
    localparam int PW        = AW + 1,
    localparam int REC_W     = 2 + CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_sof,
    input  logic             wr_valid,
    input  logic [7:0]       wr_data,
    input  logic             wr_eom,
    input  logic [1:0]       wr_eom_code,
    input  logic             rd_byte_pop,
    output logic [7:0]       rd_byte,
    output logic             rd_byte_avail,
    input  logic             rd_stat_pop,
    output logic             rd_stat_avail,
    output logic [1:0]       rd_stat_code,
    output logic [CNT_W-1:0] rd_stat_count,
    output logic             full_err
);
    logic             mem_we;
    logic [AW-1:0]    mem_waddr;
    logic [PW-1:0]    spec_ptr, commit_ptr, rd_ptr;
    logic             rec_push, stat_full, ovf_evt;
    logic [1:0]       rec_code;
    logic [CNT_W-1:0] rec_cnt;
    logic [REC_W-1:0] stat_head;
    rx_state_e        rx_state;

    rxf_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
        .clk(clk), .rst_n(rst_n),
        .sof(wr_sof), .valid(wr_valid), .eom(wr_eom), .eom_code(wr_eom_code),
        .rd_ptr(rd_ptr), .stat_full(stat_full),
        .mem_we(mem_we), .mem_waddr(mem_waddr),
        .spec_ptr(spec_ptr), .commit_ptr(commit_ptr),
        .rec_push(rec_push), .rec_code(rec_code), .rec_cnt(rec_cnt),
        .ovf_evt(ovf_evt), .state(rx_state)
    );

    rxf_byte_store #(.DEPTH(DEPTH), .W(8)) u_bytes (
        .clk(clk), .rst_n(rst_n),
        .we(mem_we), .waddr(mem_waddr), .wdata(wr_data),
        .commit_ptr(commit_ptr), .pop(rd_byte_pop),
        .rdata(rd_byte), .avail(rd_byte_avail), .rd_ptr(rd_ptr)
    );

    rxf_stat_fifo #(.DEPTH(STAT_DEPTH), .W(REC_W)) u_stat (
        .clk(clk), .rst_n(rst_n),
        .push(rec_push), .din({rec_code, rec_cnt}), .pop(rd_stat_pop),
        .head(stat_head), .not_empty(rd_stat_avail), .full(stat_full)
    );

    assign rd_stat_code  = stat_head[REC_W-1 -: 2];
    assign rd_stat_count = stat_head[CNT_W-1:0];

    // Sticky error: a new overflow wins over the clearing status pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_err <= 1'b0;
        end else if (ovf_evt) begin
            full_err <= 1'b1;
        end else if (rd_stat_pop) begin
            full_err <= 1'b0;
        end
    end
endmodule

// File: rtl/rxf_msg_fifo_chk.sv
// Property checker for rxf_msg_fifo, attached with bind below.
// Assumes write events are mutually exclusive in any cycle.
module rxf_msg_fifo_chk #(
    parameter int DEPTH = 64,
    parameter int PW    = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_sof,
    input logic          wr_eom,
    input logic          rd_stat_pop,
    input logic          rd_stat_avail,
    input logic [1:0]    rd_stat_code,
    input logic [7:0]    rd_stat_count,
    input logic          rd_byte_avail,
    input logic          full_err,
    input logic          ovf_evt,
    input logic [1:0]    rx_state,
    input logic [PW-1:0] spec_ptr,
    input logic [PW-1:0] commit_ptr,
    input logic [PW-1:0] rd_ptr
);
    logic [PW-1:0] occ;
    assign occ = spec_ptr - rd_ptr;

    assert_occ_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= PW'(DEPTH));

    assert_full_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> full_err);

    assert_full_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        full_err && !rd_stat_pop |=> full_err);

    assert_full_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat_pop && !ovf_evt |=> !full_err);

    assert_ovf_partial_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt && rx_state == 2'b01 && !wr_eom && !rd_stat_avail && !rd_stat_pop
        |=> rd_stat_avail && rd_stat_code == 2'b11 && rd_stat_count == 8'd0);

    assert_drop_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_state == 2'b10 && !wr_sof |=> $stable(spec_ptr) && $stable(commit_ptr));

    assert_hidden_open_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_state == 2'b01 && !wr_eom && !wr_sof |=> $stable(commit_ptr));

    assert_empty_pop_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_byte_avail |=> $stable(rd_ptr));
endmodule

bind rxf_msg_fifo rxf_msg_fifo_chk #(.DEPTH(DEPTH), .PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_sof(wr_sof), .wr_eom(wr_eom),
    .rd_stat_pop(rd_stat_pop), .rd_stat_avail(rd_stat_avail),
    .rd_stat_code(rd_stat_code), .rd_stat_count(rd_stat_count),
    .rd_byte_avail(rd_byte_avail), .full_err(full_err), .ovf_evt(ovf_evt),
    .rx_state(rx_state), .spec_ptr(spec_ptr), .commit_ptr(commit_ptr),
    .rd_ptr(rd_ptr)
);

// File: tb/rxf_msg_fifo_tb.sv
// Bench: directed corner cases plus seeded random messages, compared
// against a queue model built from the requirements.
module rxf_msg_fifo_tb;
    localparam int DEPTH = 64;
    localparam int SDEP  = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_sof = 1'b0, wr_valid = 1'b0, wr_eom = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] wr_eom_code = '0;
    logic       rd_byte_pop = 1'b0, rd_stat_pop = 1'b0;
    logic [7:0] rd_byte, rd_stat_count;
    logic       rd_byte_avail, rd_stat_avail, full_err;
    logic [1:0] rd_stat_code;

    always #2 clk = ~clk;

    rxf_msg_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .wr_sof(wr_sof), .wr_valid(wr_valid),
        .wr_data(wr_data), .wr_eom(wr_eom), .wr_eom_code(wr_eom_code),
        .rd_byte_pop(rd_byte_pop), .rd_byte(rd_byte), .rd_byte_avail(rd_byte_avail),
        .rd_stat_pop(rd_stat_pop), .rd_stat_avail(rd_stat_avail),
        .rd_stat_code(rd_stat_code), .rd_stat_count(rd_stat_count),
        .full_err(full_err)
    );

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    // Model state
    logic [7:0] byte_q [$];
    logic [7:0] pend [$];
    logic [9:0] rec_q [$];
    int         mstate = 0;  // 0 idle, 1 receiving, 2 dropping
    bit         mfull = 1'b0;

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic ev_sof();
        @(negedge clk); wr_sof = 1'b1;
        @(negedge clk); wr_sof = 1'b0;
        pend.delete(); mstate = 1;
    endtask

    task automatic ev_byte(logic [7:0] b);
        @(negedge clk); wr_valid = 1'b1; wr_data = b;
        @(negedge clk); wr_valid = 1'b0;
        if (mstate == 1) begin
            if (byte_q.size() + pend.size() == DEPTH) begin
                pend.delete();
                if (rec_q.size() < SDEP) rec_q.push_back({2'b11, 8'd0});
                mfull = 1'b1; mstate = 2;
            end else begin
                pend.push_back(b);
            end
        end
    endtask

    task automatic ev_eom(logic [1:0] code);
        @(negedge clk); wr_eom = 1'b1; wr_eom_code = code;
        @(negedge clk); wr_eom = 1'b0;
        if (mstate == 1) begin
            if (rec_q.size() < SDEP) begin
                rec_q.push_back({code, 8'(pend.size())});
                foreach (pend[i]) byte_q.push_back(pend[i]);
            end else begin
                mfull = 1'b1;
            end
            pend.delete(); mstate = 0;
        end
    endtask

    task automatic send_msg(int len, logic [1:0] code, logic [7:0] base);
        ev_sof();
        for (int i = 0; i < len; i++) ev_byte(8'(base + i * 7));
        ev_eom(code);
    endtask

    // Read every record and its bytes, comparing with the model.
    task automatic drain(string tag);
        @(negedge clk);
        check(full_err == mfull, {tag, " R6 full_err"}, 32'(full_err), 32'(mfull));
        while (rec_q.size() > 0) begin
            @(negedge clk);
            check(rd_stat_avail && {rd_stat_code, rd_stat_count} == rec_q[0],
                  {tag, " record"}, {rd_stat_avail, rd_stat_code, rd_stat_count},
                  {1'b1, rec_q[0]});
            for (int k = 0; k < int'(rec_q[0][7:0]); k++) begin
                check(rd_byte_avail && rd_byte == byte_q[0], {tag, " byte"},
                      {rd_byte_avail, rd_byte}, {1'b1, byte_q[0]});
                rd_byte_pop = 1'b1;
                @(negedge clk); rd_byte_pop = 1'b0;
                void'(byte_q.pop_front());
            end
            rd_stat_pop = 1'b1;
            @(negedge clk); rd_stat_pop = 1'b0;
            void'(rec_q.pop_front());
            mfull = 1'b0;
        end
        @(negedge clk);
        check(!rd_stat_avail && !rd_byte_avail && !full_err, {tag, " R6 empty after drain"},
              {rd_stat_avail, rd_byte_avail, full_err}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=hang expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!rd_byte_avail && !rd_stat_avail && !full_err, "R1 reset",
              {rd_byte_avail, rd_stat_avail, full_err}, 0);

        // R9: stray bytes and close without an open message
        ev_byte(8'h11); ev_byte(8'h22); ev_eom(2'b00);
        @(negedge clk);
        check(!rd_byte_avail && !rd_stat_avail, "R9 stray ignored",
              {rd_byte_avail, rd_stat_avail}, 0);

        // R2 with R11: good message hidden until closed
        ev_sof(); ev_byte(8'hA1); ev_byte(8'hA2); ev_byte(8'hA3);
        @(negedge clk);
        check(!rd_byte_avail, "R11 open message hidden", 32'(rd_byte_avail), 0);
        ev_byte(8'hA4); ev_byte(8'hA5); ev_eom(2'b00);
        drain("R2");

        // R8: FCS error and abort keep their bytes
        send_msg(4, 2'b01, 8'h30);
        send_msg(3, 2'b10, 8'h50);
        drain("R8");

        // R12: pop on empty has no effect
        @(negedge clk); rd_byte_pop = 1'b1;
        @(negedge clk); rd_byte_pop = 1'b0;
        send_msg(2, 2'b00, 8'hAA);
        drain("R12");

        // R3, R4, R5, R7: overflow in second message
        send_msg(20, 2'b00, 8'h01);
        ev_sof();
        for (int i = 0; i < 50; i++) ev_byte(8'(8'h80 + i));
        ev_eom(2'b00);
        @(negedge clk);
        check(full_err == 1'b1, "R6 set after overflow", 32'(full_err), 1);
        check(!rd_byte_avail || rd_byte == 8'h01, "R5 older bytes intact",
              32'(rd_byte), 32'h01);
        ev_byte(8'hEE); ev_byte(8'hEF); ev_eom(2'b00);  // R7: ignored
        check(full_err == 1'b1, "R6 held without pop", 32'(full_err), 1);
        drain("R4 R5 R7");

        // R10: status queue overflow
        for (int m = 0; m < SDEP + 1; m++) send_msg(1, 2'b00, 8'(m));
        drain("R10");

        // Random messages with occasional drains
        for (int n = 0; n < 60; n++) begin
            send_msg(int'($urandom_range(0, 30)), 2'($urandom_range(0, 2)),
                     8'($urandom));
            if ($urandom_range(0, 2) == 0) drain("R2 R3 R4 random");
        end
        drain("R5 random final");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule